// File: doc/BRIEF.md
# Execution Context Unit: Mode, Privilege and Stack Select

This block holds the execution context of a processor core: whether it runs ordinary Thread code or an exception Handler, whether Thread code is privileged, and which of two banked stack pointers (main or process) is visible as the active one. It also keeps the two-bit control register that software uses to pick the Thread-mode stack and privilege, and the link register with its reset value.

The exception logic pulses an entry strobe when an exception is taken and a leave strobe when handling ends. Software writes reach the control register through a write port that carries the privilege of the writer. Stack pointer updates arrive on their own write port and land in whichever bank is currently selected. The main stack pointer takes its reset value from an input, which is the word fetched from address 0x00000000. All state is registered with a synchronous active-high reset, and every output follows from that state, so an input that is accepted at a clock edge shows on the outputs just after that edge.

Top module: `exec_ctx_unit`

## Requirements
- R1: While reset is held and just after it is released, the unit is in Thread mode (`handler_mode`=0), `ctrl_rdata`=0, `privileged`=1, `sp_active` equals `sp_reset_val` with bits [1:0] cleared, and `lr_value` is all ones.
- R2: An `exc_enter` pulse puts the unit in Handler mode at the next edge. A `exc_leave` pulse in Handler mode returns it to Thread mode. `exc_leave` in Thread mode is ignored. When both strobes arrive in the same cycle, entry wins and the unit is in Handler mode afterwards.
- R3: Control bit 0 is the Thread privilege (0 privileged, 1 unprivileged). `privileged` is 1 in Handler mode, and in Thread mode it is 1 only when bit 0 is 0.
- R4: Control bit 1 selects the Thread stack (0 main, 1 process), and in Thread mode `sp_active` shows the selected bank.
- R5: In Handler mode `sp_active` always shows the main stack pointer, and `ctrl_rdata` bit 1 reads 0.
- R6: A privileged control write in Handler mode updates bit 0 and leaves bit 1 unchanged.
- R7: A control write with `ctrl_wr_priv`=0 has no effect on `ctrl_rdata`.
- R8: Entry from Thread mode saves the Thread value of bit 1, and the leave strobe restores it. A nested entry made while already in Handler mode does not overwrite the saved value.
- R9: A stack pointer write goes only to the bank currently shown on `sp_active` and stores the data with bits [1:0] forced to 0. The other bank keeps its value.
- R10: `ctrl_rdata` bits above bit 1 always read 0.
- R11: A control write in a cycle that also carries an accepted entry or leave strobe is dropped.
- R12: A `lr_wr_en` pulse loads `lr_wr_data` into `lr_value` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_reset_val | input | SP_W | Reset load value for the main stack pointer |
| exc_enter | input | 1 | Exception entry strobe |
| exc_leave | input | 1 | Exception handling finished strobe |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_priv | input | 1 | Writer is privileged |
| ctrl_wr_data | input | CTRL_W | Control write data; bit 1 stack select, bit 0 Thread unprivileged |
| sp_wr_en | input | 1 | Active stack pointer write strobe |
| sp_wr_data | input | SP_W | Active stack pointer write data |
| lr_wr_en | input | 1 | Link register write strobe |
| lr_wr_data | input | SP_W | Link register write data |
| handler_mode | output | 1 | 1 in Handler mode, 0 in Thread mode |
| privileged | output | 1 | Effective privilege of the running code |
| sp_active | output | SP_W | Value of the selected stack pointer bank |
| ctrl_rdata | output | CTRL_W | Control register readback |
| lr_value | output | SP_W | Link register value |

## Verification
On every cycle the assertions check the mode changes caused by each strobe, the dropping of unprivileged and event-cycle control writes, the protection of bit 1 in Handler mode, the privilege and zero stack-select readback while handling, and that a write to one stack bank leaves the other alone. Only the bench scenarios can show that the saved selection comes back with the right value after nested and tail-chained entries, that stack values survive a round trip through Handler mode, and that the reset values of the stack and link registers are correct.

// File: rtl/exec_ctx_pkg.sv
package exec_ctx_pkg;
  localparam int CTRL_BITS = 2;

  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } mode_e;

  // bit 1: Thread uses process stack, bit 0: Thread code unprivileged
  typedef struct packed {
    logic use_psp;
    logic unpriv;
  } ctrl_t;
endpackage

// File: rtl/ctx_mode_fsm.sv
module ctx_mode_fsm
  import exec_ctx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  exc_enter,
  input  logic  exc_leave,
  output mode_e mode_q,
  output logic  first_entry,
  output logic  leave_evt
);
  assign first_entry = exc_enter && (mode_q == MODE_THREAD);
  assign leave_evt   = exc_leave && !exc_enter && (mode_q == MODE_HANDLER);

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= MODE_THREAD;
    else if (exc_enter) mode_q <= MODE_HANDLER;
    else if (leave_evt) mode_q <= MODE_THREAD;
  end

  assert_enter_R2: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> (mode_q == MODE_HANDLER));
  assert_leave_R2: assert property (@(posedge clk) disable iff (rst)
    (exc_leave && !exc_enter && mode_q == MODE_HANDLER) |=> (mode_q == MODE_THREAD));
  assert_thread_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_THREAD && !exc_enter) |=> (mode_q == MODE_THREAD));
endmodule

// File: rtl/ctx_ctrl_reg.sv
module ctx_ctrl_reg
  import exec_ctx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_handler,
  input  logic  any_enter,
  input  logic  first_entry,
  input  logic  leave_evt,
  input  logic  wr_en,
  input  logic  wr_priv,
  input  ctrl_t wr_bits,
  output ctrl_t ctrl_q
);
  logic saved_psp_q;
  logic wr_ok;

  assign wr_ok = wr_en && wr_priv && !any_enter && !leave_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      saved_psp_q <= 1'b0;
    end else if (first_entry) begin
      saved_psp_q    <= ctrl_q.use_psp;
      ctrl_q.use_psp <= 1'b0;
    end else if (leave_evt) begin
      ctrl_q.use_psp <= saved_psp_q;
    end else if (wr_ok) begin
      ctrl_q.unpriv <= wr_bits.unpriv;
      if (!in_handler) ctrl_q.use_psp <= wr_bits.use_psp;
    end
  end

  assert_unpriv_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_priv && !any_enter && !leave_evt) |=> $stable(ctrl_q));
  assert_handler_sel_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (in_handler && !any_enter && !leave_evt) |=> $stable(ctrl_q.use_psp));
endmodule

// File: rtl/ctx_sp_bank.sv
module ctx_sp_bank #(
  parameter int SP_W       = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SP_W-1:0] rst_load,
  input  logic            sel_psp,
  input  logic            wr_en,
  input  logic [SP_W-1:0] wr_data,
  output logic [SP_W-1:0] sp_out
);
  localparam logic [SP_W-1:0] ALIGN_MASK = ~((SP_W)'((1 << ALIGN_BITS) - 1));

  logic [SP_W-1:0] msp_q;
  logic [SP_W-1:0] psp_q;

  always_ff @(posedge clk) begin
    if (rst)                    msp_q <= rst_load & ALIGN_MASK;
    else if (wr_en && !sel_psp) msp_q <= wr_data & ALIGN_MASK;
  end

  // process stack has no defined reset value
  always_ff @(posedge clk) begin
    if (wr_en && sel_psp) psp_q <= wr_data & ALIGN_MASK;
  end

  assign sp_out = sel_psp ? psp_q : msp_q;

  assert_psp_wr_keeps_msp_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_psp) |=> $stable(msp_q));
  assert_msp_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    !sel_psp |-> (sp_out[ALIGN_BITS-1:0] == '0));
endmodule

// File: rtl/exec_ctx_unit.sv
module exec_ctx_unit
  import exec_ctx_pkg::*;
#(
  parameter int SP_W     = 32,
  parameter int CTRL_W   = 32,
  parameter int SP_ALIGN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SP_W-1:0]   sp_reset_val,
  input  logic              exc_enter,
  input  logic              exc_leave,
  input  logic              ctrl_wr_en,
  input  logic              ctrl_wr_priv,
  input  logic [CTRL_W-1:0] ctrl_wr_data,
  input  logic              sp_wr_en,
  input  logic [SP_W-1:0]   sp_wr_data,
  input  logic              lr_wr_en,
  input  logic [SP_W-1:0]   lr_wr_data,
  output logic              handler_mode,
  output logic              privileged,
  output logic [SP_W-1:0]   sp_active,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output logic [SP_W-1:0]   lr_value
);
  localparam int PAD_W = CTRL_W - CTRL_BITS;

  mode_e mode_q;
  logic  first_entry, leave_evt, in_handler, sel_psp;
  ctrl_t ctrl_q, wr_bits;
  logic [SP_W-1:0] lr_q;

  assign in_handler = (mode_q == MODE_HANDLER);
  assign wr_bits    = ctrl_t'(ctrl_wr_data[CTRL_BITS-1:0]);

  ctx_mode_fsm u_mode (
    .clk(clk), .rst(rst), .exc_enter(exc_enter), .exc_leave(exc_leave),
    .mode_q(mode_q), .first_entry(first_entry), .leave_evt(leave_evt)
  );

  ctx_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .in_handler(in_handler), .any_enter(exc_enter),
    .first_entry(first_entry), .leave_evt(leave_evt), .wr_en(ctrl_wr_en),
    .wr_priv(ctrl_wr_priv), .wr_bits(wr_bits), .ctrl_q(ctrl_q)
  );

  assign sel_psp = !in_handler && ctrl_q.use_psp;

  ctx_sp_bank #(.SP_W(SP_W), .ALIGN_BITS(SP_ALIGN)) u_sp (
    .clk(clk), .rst(rst), .rst_load(sp_reset_val), .sel_psp(sel_psp),
    .wr_en(sp_wr_en), .wr_data(sp_wr_data), .sp_out(sp_active)
  );

  always_ff @(posedge clk) begin
    if (rst)           lr_q <= '1;
    else if (lr_wr_en) lr_q <= lr_wr_data;
  end

  assign handler_mode = in_handler;
  assign privileged   = in_handler || !ctrl_q.unpriv;
  assign ctrl_rdata   = {{PAD_W{1'b0}}, ctrl_q};
  assign lr_value     = lr_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!handler_mode && privileged && ctrl_rdata == '0 && lr_value == '1));
  assert_handler_priv_R3: assert property (@(posedge clk) disable iff (rst)
    handler_mode |-> privileged);
  assert_handler_sel_zero_R5: assert property (@(posedge clk) disable iff (rst)
    handler_mode |-> (ctrl_rdata[1] == 1'b0));
  assert_event_write_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr_en && exc_enter && handler_mode) |=> $stable(ctrl_rdata));
endmodule

// File: tb/sim_exec_ctx_unit.sv
module sim_exec_ctx_unit;
  localparam int CLK_PERIOD = 10;
  localparam int SP_W = 32;
  localparam int CTRL_W = 32;
  localparam logic [31:0] RST_SP = 32'h2000_1003;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exc_enter = 0, exc_leave = 0, ctrl_wr_en = 0, ctrl_wr_priv = 0;
  logic sp_wr_en = 0, lr_wr_en = 0;
  logic [CTRL_W-1:0] ctrl_wr_data = '0;
  logic [SP_W-1:0] sp_wr_data = '0, lr_wr_data = '0;
  logic handler_mode, privileged;
  logic [SP_W-1:0] sp_active, lr_value;
  logic [CTRL_W-1:0] ctrl_rdata;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_ctx_unit #(.SP_W(SP_W), .CTRL_W(CTRL_W), .SP_ALIGN(2)) u0 (
    .clk(clk), .rst(rst), .sp_reset_val(RST_SP),
    .exc_enter(exc_enter), .exc_leave(exc_leave),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_priv(ctrl_wr_priv), .ctrl_wr_data(ctrl_wr_data),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .lr_wr_en(lr_wr_en), .lr_wr_data(lr_wr_data),
    .handler_mode(handler_mode), .privileged(privileged), .sp_active(sp_active),
    .ctrl_rdata(ctrl_rdata), .lr_value(lr_value)
  );

  // vector: [9]enter [8]leave [7]wr_en [6]wr_priv [5:4]wr_data
  //         [3]exp handler [2]exp privileged [1:0]exp ctrl readback
  localparam logic [9:0] VEC [12] = '{
    10'b0011_10_0_1_10,  // R4 privileged write selects process stack
    10'b1000_00_1_1_00,  // R2 R8 entry saves sel, R5 reads zero
    10'b0011_11_1_1_01,  // R6 handler write: bit0 taken, bit1 ignored
    10'b0100_00_0_0_11,  // R8 leave restores sel, R3 unprivileged
    10'b0010_00_0_0_11,  // R7 unprivileged write dropped
    10'b0100_00_0_0_11,  // R2 leave in Thread ignored
    10'b1100_00_1_1_01,  // R2 both strobes: entry wins
    10'b1000_00_1_1_01,  // R8 nested entry keeps saved sel
    10'b1011_00_1_1_01,  // R11 write with entry dropped
    10'b0100_00_0_0_11,  // R8 saved sel survives nesting
    10'b0011_00_0_1_00,  // R4 R3 privileged write clears both
    10'b0011_01_0_0_01   // R3 Thread unprivileged
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic lv, input logic we, input logic wp,
                      input logic [1:0] wd, input logic spw, input logic [31:0] spd);
    exc_enter = en; exc_leave = lv; ctrl_wr_en = we; ctrl_wr_priv = wp;
    ctrl_wr_data = {30'h3FFF_FFFF, wd};
    sp_wr_en = spw; sp_wr_data = spd;
    @(posedge clk); @(negedge clk);
    exc_enter = 0; exc_leave = 0; ctrl_wr_en = 0; ctrl_wr_priv = 0; sp_wr_en = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 handler_mode", 64'(handler_mode), 64'd0);
    chk("R1 privileged", 64'(privileged), 64'd1);
    chk("R1 ctrl_rdata", 64'(ctrl_rdata), 64'd0);
    chk("R1 sp_active", 64'(sp_active), 64'h2000_1000);
    chk("R1 lr_value", 64'(lr_value), 64'hFFFF_FFFF);

    for (int i = 0; i < 12; i++) begin
      logic [9:0] v;
      v = VEC[i];
      step(v[9], v[8], v[7], v[6], v[5:4], 1'b0, 32'h0);
      chk($sformatf("R2 vec%0d handler", i), 64'(handler_mode), 64'(v[3]));
      chk($sformatf("R3 vec%0d privileged", i), 64'(privileged), 64'(v[2]));
      chk($sformatf("R10 vec%0d ctrl_rdata", i), 64'(ctrl_rdata), 64'({30'h0, v[1:0]}));
    end

    do_reset();
    step(0, 0, 0, 0, 2'b00, 1, 32'h1234_5677);
    chk("R9 main write aligned", 64'(sp_active), 64'h1234_5674);
    step(0, 0, 1, 1, 2'b10, 0, 32'h0);
    step(0, 0, 0, 0, 2'b00, 1, 32'hAAAA_0001);
    chk("R4 process stack written", 64'(sp_active), 64'hAAAA_0000);
    step(1, 0, 0, 0, 2'b00, 0, 32'h0);
    chk("R5 handler shows main", 64'(sp_active), 64'h1234_5674);
    step(0, 0, 0, 0, 2'b00, 1, 32'h3000_0008);
    chk("R9 handler write to main", 64'(sp_active), 64'h3000_0008);
    step(0, 1, 0, 0, 2'b00, 0, 32'h0);
    chk("R9 process kept", 64'(sp_active), 64'hAAAA_0000);
    step(0, 0, 1, 1, 2'b00, 0, 32'h0);
    chk("R4 back to main", 64'(sp_active), 64'h3000_0008);
    step(0, 0, 1, 0, 2'b10, 0, 32'h0);
    chk("R7 unpriv select ignored", 64'(sp_active), 64'h3000_0008);

    lr_wr_en = 1; lr_wr_data = 32'h0800_0101;
    @(posedge clk); @(negedge clk);
    lr_wr_en = 0;
    chk("R12 lr write", 64'(lr_value), 64'h0800_0101);

    do_reset();
    chk("R1 lr after reset", 64'(lr_value), 64'hFFFF_FFFF);
    chk("R1 sp after reset", 64'(sp_active), 64'h2000_1000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule